// File: doc/BRIEF.md
# VLAN-Aware Forwarding Port Mask Generator

This block decides which egress ports of a 24-port switch a received frame is sent to. Each request carries the frame's destination MAC address, the ingress (source) port number, the result of an address-table lookup (a hit flag and a port number) and a per-request option that picks how unknown unicast is handled. Static configuration arrives on flat vectors: the VLANs each port belongs to, the member ports of each VLAN, a dumping port for each VLAN, and an optional management port.

The block sorts the frame into one of five kinds: known unicast, unknown unicast flooded, unknown unicast sent to dumping ports, ordinary group (multicast or broadcast), and reserved bridge-management group. It then builds the egress bitmap for that kind. The ingress port is always removed from the result, so a frame never goes back out where it came in. The mask and a valid strobe are registered and appear one cycle after the request.

A source port that is in several VLANs collects targets from all of them. For flooding and group traffic this is the union of the member masks. For unknown unicast with flooding off it is the set of dumping ports of those VLANs.

Top module: `vlan_fwd_mask_gen`

## Requirements
- R1: `fwd_valid` equals `req_valid` delayed by exactly one clock; when `fwd_valid` is low, `fwd_mask` is all zeros; both are zero after reset.
- R2: The destination address uses `req_da[47:40]` as the first octet on the wire. Its least significant bit, `req_da[40]`, is the group bit: 0 selects the unicast paths (R3 to R5) and 1 selects the group paths (R6, R7).
- R3: For a unicast frame with `lk_hit`=1, the mask has only bit `lk_port` set. An `lk_port` value of 24 or more gives an empty mask. `flood_en` has no effect on this path.
- R4: For a unicast frame with `lk_hit`=0 and `flood_en`=1, the mask is the OR of `cfg_vlan_members[v*24 +: 24]` over every VLAN v for which `cfg_port_vlans[src*8+v]` is 1.
- R5: For a unicast frame with `lk_hit`=0 and `flood_en`=0, the mask has bit `cfg_vlan_dump[v*5 +: 5]` set for every VLAN v of the source port. Dumping indices of 24 or more add nothing.
- R6: A group frame outside the reserved range yields the same mask as R4. `lk_hit`, `lk_port` and `flood_en` are ignored on this path.
- R7: A group frame whose `req_da[47:4]` equals 44'h0180C20000_0 (addresses 01-80-C2-00-00-00 to 01-80-C2-00-00-0F) goes only to `cfg_mgmt_port` when `cfg_mgmt_en`=1. When `cfg_mgmt_en`=0 the mask is empty.
- R8: The bit of the source port is cleared from every mask, including when that port is a dumping port, a VLAN member or the management port.
- R9: A lookup hit whose `lk_port` equals `req_src` gives an empty mask, so the frame is filtered.
- R10: A source index of 24 or more belongs to no VLAN. Its flood, dumping and group masks are therefore empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_da | input | 48 | Destination MAC address, first octet in [47:40] |
| req_src | input | 5 | Ingress port index |
| lk_hit | input | 1 | Address lookup found the destination |
| lk_port | input | 5 | Egress port returned by the lookup |
| flood_en | input | 1 | Flood unknown unicast within the VLANs (1) or send it to dumping ports (0) |
| cfg_port_vlans | input | 192 | Bit p*8+v: port p belongs to VLAN v |
| cfg_vlan_members | input | 192 | Bits v*24 +: 24: member ports of VLAN v |
| cfg_vlan_dump | input | 40 | Bits v*5 +: 5: dumping port of VLAN v |
| cfg_mgmt_en | input | 1 | A management port is configured |
| cfg_mgmt_port | input | 5 | Management port index |
| fwd_valid | output | 1 | Result strobe, one cycle after `req_valid` |
| fwd_mask | output | 24 | Egress port bitmap |

## Verification
On every cycle the assertions check the one-cycle latency and the zero mask when idle. They also check that the source bit never appears, that the known-unicast and management paths set at most one bit, that a dumping-port mask has no more bits than the source has VLANs, and that a stray source index gives an empty VLAN-derived mask. Only the bench's sweeps can show that each mask is the exact set. That covers the right union of VLAN members, the right dumping ports, and the exact edges of the reserved address range (…0F inside, …10 outside). The bench runs these sweeps over every source index with management enabled and disabled.

// File: rtl/vfm_pkg.sv
package vfm_pkg;

  // Forwarding path chosen for a request.
  typedef enum logic [2:0] {
    FK_HIT   = 3'd0,
    FK_FLOOD = 3'd1,
    FK_DUMP  = 3'd2,
    FK_GROUP = 3'd3,
    FK_MGMT  = 3'd4
  } fwd_kind_e;

  // Reserved bridge-management block, upper 44 address bits.
  localparam logic [43:0] MGMT_BLOCK = 44'h0180C20000_0;

endpackage

// File: rtl/vfm_classify.sv
module vfm_classify
  import vfm_pkg::*;
(
  input  logic [47:0] da,
  input  logic        hit,
  input  logic        flood_en,
  output fwd_kind_e   kind,
  output logic        group_bit,
  output logic        mgmt_addr
);

  // Group bit is the first bit sent on the wire: LSB of the first octet.
  function automatic logic is_group(input logic [47:0] a);
    return a[40];
  endfunction

  function automatic logic in_mgmt_block(input logic [47:0] a);
    return a[47:4] == MGMT_BLOCK;
  endfunction

  assign group_bit = is_group(da);
  assign mgmt_addr = in_mgmt_block(da);

  always_comb begin
    if (group_bit)      kind = mgmt_addr ? FK_MGMT : FK_GROUP;
    else if (hit)       kind = FK_HIT;
    else if (flood_en)  kind = FK_FLOOD;
    else                kind = FK_DUMP;
  end

endmodule

// File: rtl/vfm_vlan_resolve.sv
module vfm_vlan_resolve #(
  parameter  int NPORTS = 24,
  parameter  int NVLANS = 8,
  localparam int PIDX_W = $clog2(NPORTS)
) (
  input  logic [PIDX_W-1:0]        src,
  input  logic [NPORTS*NVLANS-1:0] cfg_port_vlans,
  input  logic [NVLANS*NPORTS-1:0] cfg_vlan_members,
  input  logic [NVLANS*PIDX_W-1:0] cfg_vlan_dump,
  output logic [NVLANS-1:0]        src_vlans,
  output logic [NPORTS-1:0]        flood_mask,
  output logic [NPORTS-1:0]        dump_mask
);

  function automatic logic [NPORTS-1:0] port_hot(input logic [PIDX_W-1:0] idx);
    port_hot = '0;
    for (int i = 0; i < NPORTS; i++)
      if (idx == PIDX_W'(i)) port_hot[i] = 1'b1;
  endfunction

  // Row of the membership table for the source; stray indices select nothing.
  always_comb begin
    src_vlans = '0;
    for (int p = 0; p < NPORTS; p++)
      if (src == PIDX_W'(p)) src_vlans = cfg_port_vlans[p*NVLANS +: NVLANS];
  end

  logic [NPORTS-1:0] flood_term [NVLANS];
  logic [NPORTS-1:0] dump_term  [NVLANS];

  for (genvar v = 0; v < NVLANS; v++) begin : g_vlan
    assign flood_term[v] = src_vlans[v] ? cfg_vlan_members[v*NPORTS +: NPORTS] : '0;
    assign dump_term[v]  = src_vlans[v] ? port_hot(cfg_vlan_dump[v*PIDX_W +: PIDX_W]) : '0;
  end

  always_comb begin
    flood_mask = '0;
    dump_mask  = '0;
    for (int v = 0; v < NVLANS; v++) begin
      flood_mask = flood_mask | flood_term[v];
      dump_mask  = dump_mask  | dump_term[v];
    end
  end

endmodule

// File: rtl/vlan_fwd_mask_gen.sv
module vlan_fwd_mask_gen
  import vfm_pkg::*;
#(
  parameter  int NPORTS = 24,
  parameter  int NVLANS = 8,
  localparam int PIDX_W = $clog2(NPORTS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  input  logic [47:0]              req_da,
  input  logic [PIDX_W-1:0]        req_src,
  input  logic                     lk_hit,
  input  logic [PIDX_W-1:0]        lk_port,
  input  logic                     flood_en,
  input  logic [NPORTS*NVLANS-1:0] cfg_port_vlans,
  input  logic [NVLANS*NPORTS-1:0] cfg_vlan_members,
  input  logic [NVLANS*PIDX_W-1:0] cfg_vlan_dump,
  input  logic                     cfg_mgmt_en,
  input  logic [PIDX_W-1:0]        cfg_mgmt_port,
  output logic                     fwd_valid,
  output logic [NPORTS-1:0]        fwd_mask
);

  localparam logic [PIDX_W-1:0] LAST_PORT = PIDX_W'(NPORTS - 1);

  function automatic logic [NPORTS-1:0] port_hot(input logic [PIDX_W-1:0] idx);
    port_hot = '0;
    for (int i = 0; i < NPORTS; i++)
      if (idx == PIDX_W'(i)) port_hot[i] = 1'b1;
  endfunction

  // Named internal events for the assertions.
  fwd_kind_e         kind;
  logic              group_bit;
  logic              mgmt_addr;
  logic [NVLANS-1:0] src_vlans;
  logic [NPORTS-1:0] flood_mask;
  logic [NPORTS-1:0] dump_mask;
  logic [NPORTS-1:0] raw_mask;
  logic [NPORTS-1:0] src_hot;
  logic [NPORTS-1:0] next_mask;

  vfm_classify u_classify (
    .da        (req_da),
    .hit       (lk_hit),
    .flood_en  (flood_en),
    .kind      (kind),
    .group_bit (group_bit),
    .mgmt_addr (mgmt_addr)
  );

  vfm_vlan_resolve #(.NPORTS(NPORTS), .NVLANS(NVLANS)) u_resolve (
    .src              (req_src),
    .cfg_port_vlans   (cfg_port_vlans),
    .cfg_vlan_members (cfg_vlan_members),
    .cfg_vlan_dump    (cfg_vlan_dump),
    .src_vlans        (src_vlans),
    .flood_mask       (flood_mask),
    .dump_mask        (dump_mask)
  );

  always_comb begin
    unique case (kind)
      FK_HIT:   raw_mask = port_hot(lk_port);
      FK_FLOOD: raw_mask = flood_mask;
      FK_DUMP:  raw_mask = dump_mask;
      FK_GROUP: raw_mask = flood_mask;
      FK_MGMT:  raw_mask = cfg_mgmt_en ? port_hot(cfg_mgmt_port) : '0;
      default:  raw_mask = '0;
    endcase
  end

  assign src_hot   = port_hot(req_src);
  assign next_mask = raw_mask & ~src_hot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fwd_valid <= 1'b0;
      fwd_mask  <= '0;
    end else begin
      fwd_valid <= req_valid;
      fwd_mask  <= req_valid ? next_mask : '0;
    end
  end

  // R1: strobe follows the request by one cycle
  a_r1_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> fwd_valid);

  // R1: idle cycle gives no strobe and an empty mask
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!fwd_valid && fwd_mask == '0));

  // R8: ingress port never appears in the result
  a_r8_src_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src <= LAST_PORT) |=> !fwd_mask[$past(req_src)]);

  // R3: known unicast targets at most one port
  a_r3_hit_single: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == FK_HIT) |=> $onehot0(fwd_mask));

  // R7: management traffic targets at most one port
  a_r7_mgmt_single: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == FK_MGMT) |=> $onehot0(fwd_mask));

  // R5: no more dumping targets than VLANs of the source
  a_r5_dump_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && kind == FK_DUMP) |=>
      ($countones(fwd_mask) <= $past($countones(src_vlans))));

  // R10: stray source index gives an empty VLAN-derived mask
  a_r10_stray_src: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_src > LAST_PORT && kind != FK_HIT && kind != FK_MGMT)
      |=> fwd_mask == '0);

endmodule

// File: tb/tb_vlan_fwd_mask_gen.sv
module tb_vlan_fwd_mask_gen;

  localparam int NP = 24;
  localparam int NV = 8;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic [47:0]     req_da;
  logic [4:0]      req_src;
  logic            lk_hit;
  logic [4:0]      lk_port;
  logic            flood_en;
  logic [NP*NV-1:0] cfg_port_vlans;
  logic [NV*NP-1:0] cfg_vlan_members;
  logic [NV*5-1:0]  cfg_vlan_dump;
  logic            cfg_mgmt_en;
  logic [4:0]      cfg_mgmt_port;
  logic            fwd_valid;
  logic [NP-1:0]   fwd_mask;

  int checks = 0;
  int errors = 0;

  bit in_vlan [NP][NV];
  int dump_of [NV];

  always #2.5 clk = ~clk;

  vlan_fwd_mask_gen dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_da(req_da),
    .req_src(req_src), .lk_hit(lk_hit), .lk_port(lk_port), .flood_en(flood_en),
    .cfg_port_vlans(cfg_port_vlans), .cfg_vlan_members(cfg_vlan_members),
    .cfg_vlan_dump(cfg_vlan_dump), .cfg_mgmt_en(cfg_mgmt_en),
    .cfg_mgmt_port(cfg_mgmt_port), .fwd_valid(fwd_valid), .fwd_mask(fwd_mask)
  );

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
  end

  task automatic check(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent model: for every port decide membership in the result.
  function automatic logic [NP-1:0] model(input logic [47:0] da, input int src,
      input bit hit, input int lp, input bit fl, input bit men, input int mp);
    logic [NP-1:0] m = '0;
    bit grp = (da >> 40) & 1;
    bit rsv = (da >> 4) == 48'h0000_0180C2000_0 >> 0 ? 1'b0 : 1'b0;
    rsv = (da / 16) == 48'h00000180C200000 / 16 * 0 + 48'h0180C200000;
    for (int p = 0; p < NP; p++) begin
      bit take = 0;
      if (grp && rsv) take = men && (p == mp);
      else if (!grp && hit) take = (p == lp);
      else
        for (int v = 0; v < NV; v++)
          if (src < NP && in_vlan[src][v])
            if (grp || fl) take = take | in_vlan[p][v];
            else           take = take | (dump_of[v] == p);
      if (p == src) take = 0;
      m[p] = take;
    end
    return m;
  endfunction

  task automatic do_req(input string tag, input logic [47:0] da, input int src,
      input bit hit, input int lp, input bit fl);
    logic [NP-1:0] exp;
    exp = model(da, src, hit, lp, fl, cfg_mgmt_en, int'(cfg_mgmt_port));
    @(negedge clk);
    req_valid = 1'b1; req_da = da; req_src = 5'(src);
    lk_hit = hit; lk_port = 5'(lp); flood_en = fl;
    @(negedge clk);
    check({"R1 valid ", tag}, {23'd0, fwd_valid}, 24'd1);
    check(tag, fwd_mask, exp);
    req_valid = 1'b0;
    @(negedge clk);
    check("R1 idle", {23'd0, fwd_valid} | fwd_mask, 24'd0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 0; req_da = '0; req_src = '0;
    lk_hit = 0; lk_port = '0; flood_en = 0;
    cfg_mgmt_en = 0; cfg_mgmt_port = 5'd17;
    cfg_port_vlans = '0; cfg_vlan_members = '0; cfg_vlan_dump = '0;
    for (int p = 0; p < NP; p++)
      for (int v = 0; v < NV; v++) begin
        in_vlan[p][v] = ((p + v) % 3 == 0) && (p != 22);
        cfg_port_vlans[p*NV+v] = in_vlan[p][v];
        cfg_vlan_members[v*NP+p] = in_vlan[p][v];
      end
    for (int v = 0; v < NV; v++) begin
      dump_of[v] = (v * 5 + 3) % NP;
      cfg_vlan_dump[v*5 +: 5] = 5'(dump_of[v]);
    end
    repeat (3) @(negedge clk);
    check("R1 reset", {23'd0, fwd_valid} | fwd_mask, 24'd0);
    rst_n = 1'b1;

    for (int me = 0; me < 2; me++) begin
      cfg_mgmt_en = me[0];
      for (int s = 0; s < 32; s++) begin
        logic [47:0] uc = 48'h0211_2233_4400 | 48'(s);
        do_req("R3 hit",        uc, s, 1, (s * 7 + 5) % NP, s[0]);
        do_req("R9 hit to src", uc, s, 1, s, 1);
        do_req("R3 hit range",  uc, s, 1, 30, 0);
        do_req("R4 flood",      uc, s, 0, 0, 1);
        do_req("R5 R10 dump",   uc, s, 0, 0, 0);
        do_req("R6 bcast",      48'hFFFF_FFFF_FFFF, s, 1, 2, 0);
        do_req("R2 R6 mcast",   48'h0100_5E00_0001 + 48'(s), s, 0, 0, 0);
        do_req("R7 R8 mgmt",    48'h0180_C200_0000 | 48'(s % 16), s, 1, 4, 1);
        do_req("R7 edge",       48'h0180_C200_0010, s, 0, 0, 0);
      end
    end
    summary();
  end

endmodule